// File: doc/BRIEF.md
# Data Object Mailbox Register Front End

This block sits behind a configuration-space register port and runs a request/response mailbox. Software writes the dwords of a request object into a write-data mailbox. It then sets the Go bit in the control register. The block checks the object header against a parameterised table of supported protocols, and checks the dword count against the length the header declares. If both checks pass, it hands the request to an external protocol handler through a one-cycle valid pulse. The handler reads the request dwords over a random-access port, appends response dwords, and finishes with a done strobe that carries a success flag.

Software drains the response by reading the read-data mailbox and then writing to that register to step to the next dword. When the last dword has been consumed, both mailboxes empty. The status register reports Busy, Interrupt Status, Error and Ready. Abort flushes every piece of state. A single interrupt-request pulse is raised when Ready or Error becomes set, provided interrupts are supported and enabled.

Top module: `objmb_regs`

## Requirements
- R1: The register map is 0x00 capability, 0x04 control, 0x08 status, 0x0C write mailbox, 0x10 read mailbox. A write to 0x0C with all four byte enables set appends the dword to the request. A write with fewer byte enables is ignored. An append when the mailbox already holds DEPTH dwords sets Error.
- R2: The declared length is bits 17:0 of request dword 1, and a value of 0 means 2^18 dwords. Go dispatches only when dword 0 equals an entry of the protocol table and the received count equals the declared length. Otherwise the request is dropped without a trace and both mailboxes empty.
- R3: Go (control bit 31) is ignored while Error is set and while Busy is set.
- R4: A dispatch raises hdl_valid for one cycle, with hdl_sel holding the index of the lowest matching table entry. Busy (status bit 0) is held from then until the handler's done strobe.
- R5: A done strobe with hdl_ok high sets Ready (status bit 31). With hdl_ok low, both mailboxes empty and Ready stays clear.
- R6: A control write with bit 0 set and byte 0 enabled clears Ready, Error and Busy and empties both mailboxes. All other bits of that write are ignored.
- R7: The control register reads back only interrupt enable in bit 1; Abort and Go read as 0. The capability register reads interrupt-supported in bit 0 and the vector number in bits 11:1.
- R8: The status register reads Busy in bit 0, Interrupt Status in bit 1, Error in bit 2 and Ready in bit 31. All other bits read as 0.
- R9: A full-dword read of 0x10 returns the response dword at the current read index when Ready is set and Error is clear. In every other case it returns 0.
- R10: A full-dword write to 0x10 advances the read index. When the index reaches the response length, both mailboxes empty and Ready clears. A write when the index already equals the response length sets Error.
- R11: Interrupt Status is cleared by writing 1 to status bit 1. When Ready or Error is set while interrupts are supported and enabled, and Interrupt Status is not already set, Interrupt Status sets and irq pulses for one cycle. A clear and a set event in the same cycle leave it set and issue a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte address inside the register window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, masked by byte enables |
| hdl_valid | output | 1 | One-cycle dispatch pulse to the handler |
| hdl_sel | output | SELW | Index of the matched protocol |
| hreq_idx | input | $clog2(DEPTH)+1 | Handler read index into the request |
| hreq_data | output | 32 | Request dword at hreq_idx |
| hrsp_we | input | 1 | Handler appends a response dword |
| hrsp_data | input | 32 | Response dword |
| hdl_done | input | 1 | Handler completion strobe |
| hdl_ok | input | 1 | Handler success flag, sampled with hdl_done |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The handler's completion and a software write-1-to-clear of Interrupt Status can land on the same clock edge. This is the case where the order of clearing and setting decides whether an interrupt is lost. The bench plays the handler. It first leaves Interrupt Status set from an earlier response. It then drives hdl_done with success in exactly the cycle that carries the status clear write. The expected result is Interrupt Status still set, Ready set, and exactly one more irq pulse. A second pairing, Abort against a pending handler, is judged by requiring that a later done strobe produces neither Ready nor a pulse.

// File: rtl/objmb_pkg.sv
// Shared definitions for the data object mailbox front end.
// Assumes dword-aligned register accesses; slot is the address divided by four.
package objmb_pkg;
    localparam int LEN_BITS = 18;

    typedef enum logic [2:0] {
        SLOT_CAP  = 3'd0,
        SLOT_CTRL = 3'd1,
        SLOT_STAT = 3'd2,
        SLOT_WMB  = 3'd3,
        SLOT_RMB  = 3'd4
    } slot_e;

    localparam int CTRL_ABORT = 0;
    localparam int CTRL_IEN   = 1;
    localparam int CTRL_GO    = 31;
    localparam int ST_BUSY    = 0;
    localparam int ST_INT     = 1;
    localparam int ST_ERR     = 2;
    localparam int ST_RDY     = 31;

    // Declared object length in dwords; a zero field stands for the maximum.
    function automatic logic [LEN_BITS:0] obj_len(input logic [31:0] hdr1);
        if (hdr1[LEN_BITS-1:0] == '0)
            return {1'b1, {LEN_BITS{1'b0}}};
        return {1'b0, hdr1[LEN_BITS-1:0]};
    endfunction
endpackage

// File: rtl/objmb_dwbuf.sv
// Dword buffer used for both mailboxes: appends at the tail, random read by index.
// Assumes DEPTH >= 2. Appends while full are dropped (the caller flags the error).
// A clear empties the buffer and wins over an append in the same cycle.
module objmb_dwbuf #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [31:0]   push_data,
    input  logic [CW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [31:0] mem [DEPTH];

    assign full = (count == CW'(DEPTH));

    // Store an appended dword at the tail slot.
    always_ff @(posedge clk) begin
        if (push && !full && !clear)
            mem[count[AW-1:0]] <= push_data;
    end

    // Track the number of stored dwords.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (push && !full)
            count <= count + 1'b1;
    end

    // Indexed read; out-of-range indices read as zero.
    assign rd_data = (rd_idx < CW'(DEPTH)) ? mem[rd_idx[AW-1:0]] : '0;

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/objmb_match.sv
// Compares request header dword 0 against a table of supported protocol identifiers.
// Each table entry is 24 bits: object type in 23:16, vendor in 15:0; header bits 31:24 must be 0.
// The lowest matching entry index is reported.
module objmb_match #(
    parameter  int                     NUM_PROT = 2,
    parameter  logic [NUM_PROT*24-1:0] PROT_IDS = '0,
    localparam int                     SELW     = (NUM_PROT > 1) ? $clog2(NUM_PROT) : 1
) (
    input  logic [31:0]     hdr0,
    output logic            hit,
    output logic [SELW-1:0] sel
);
    logic [NUM_PROT-1:0] eq;

    for (genvar g = 0; g < NUM_PROT; g++) begin : g_cmp
        assign eq[g] = (hdr0 == {8'h00, PROT_IDS[g*24 +: 24]});
    end

    // Priority-encode the lowest matching entry.
    always_comb begin
        hit = |eq;
        sel = '0;
        for (int i = NUM_PROT - 1; i >= 0; i--)
            if (eq[i]) sel = SELW'(i);
    end
endmodule

// File: rtl/objmb_regs.sv
// Register front end of a request/response data object mailbox.
// Decodes dword-aligned register accesses, collects a request, validates it on Go,
// dispatches it to an external handler, and streams the response back to software.
// Assumes single-cycle register accesses and a handler that only appends while Busy.
module objmb_regs #(
    parameter  int                     DEPTH     = 64,
    parameter  int                     NUM_PROT  = 2,
    parameter  logic [NUM_PROT*24-1:0] PROT_IDS  = {24'h11ABCD, 24'h051234},
    parameter  logic                   INTR_SUPP = 1'b1,
    parameter  logic [10:0]            INTR_VEC  = 11'd0,
    localparam int                     CW        = $clog2(DEPTH) + 1,
    localparam int                     SELW      = (NUM_PROT > 1) ? $clog2(NUM_PROT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [3:0]      reg_be,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            hdl_valid,
    output logic [SELW-1:0] hdl_sel,
    input  logic [CW-1:0]   hreq_idx,
    output logic [31:0]     hreq_data,
    input  logic            hrsp_we,
    input  logic [31:0]     hrsp_data,
    input  logic            hdl_done,
    input  logic            hdl_ok,
    output logic            irq
);
    import objmb_pkg::*;

    logic            aligned, full_dw;
    slot_e           slot;
    logic            wr_ctrl, wr_stat, wr_wmb, wr_rmb;
    logic            abort, go_try, go_ok, go_drop, done_evt, ok_evt;
    logic            clear_mbx, drain_end, ovf_err, und_err, set_evt, int_clr, int_base, fire;
    logic            busy_q, ready_q, err_q, ien_q, intr_q;
    logic [31:0]     hdr0_q, hdr1_q;
    logic [CW-1:0]   wcount, rcount, ridx_q;
    logic            wfull, rfull_unused;
    logic [31:0]     rbuf_data, raw;
    logic            hit;
    logic [SELW-1:0] hit_sel;
    logic            req_ok;

    // Access decode: only aligned accesses reach a register.
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign full_dw = (reg_be == 4'hF);
    assign slot    = slot_e'(reg_addr[4:2]);
    assign wr_ctrl = reg_wr && aligned && slot == SLOT_CTRL;
    assign wr_stat = reg_wr && aligned && slot == SLOT_STAT;
    assign wr_wmb  = reg_wr && aligned && slot == SLOT_WMB && full_dw;
    assign wr_rmb  = reg_wr && aligned && slot == SLOT_RMB && full_dw;

    // Control actions: abort overrides everything else in the same write.
    assign abort    = wr_ctrl && reg_be[0] && reg_wdata[CTRL_ABORT];
    assign go_try   = wr_ctrl && !abort && reg_be[3] && reg_wdata[CTRL_GO];
    assign req_ok   = hit && (wcount >= CW'(2)) &&
                      (32'(obj_len(hdr1_q)) == 32'(wcount));
    assign go_ok    = go_try && !err_q && !busy_q && req_ok;
    assign go_drop  = go_try && !err_q && !busy_q && !req_ok;
    assign done_evt = hdl_done && busy_q && !abort;
    assign ok_evt   = done_evt && hdl_ok;

    // Read-mailbox stepping and its end and underrun conditions.
    assign drain_end = wr_rmb && (ridx_q < rcount) && (ridx_q + 1'b1 == rcount);
    assign und_err   = wr_rmb && (ridx_q >= rcount);
    assign ovf_err   = wr_wmb && wfull;
    assign clear_mbx = abort || go_drop || (done_evt && !hdl_ok) || drain_end;

    objmb_match #(.NUM_PROT(NUM_PROT), .PROT_IDS(PROT_IDS)) u_match (
        .hdr0 (hdr0_q),
        .hit  (hit),
        .sel  (hit_sel)
    );

    objmb_dwbuf #(.DEPTH(DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_mbx),
        .push      (wr_wmb),
        .push_data (reg_wdata),
        .rd_idx    (hreq_idx),
        .rd_data   (hreq_data),
        .count     (wcount),
        .full      (wfull)
    );

    objmb_dwbuf #(.DEPTH(DEPTH)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_mbx),
        .push      (hrsp_we && busy_q),
        .push_data (hrsp_data),
        .rd_idx    (ridx_q),
        .rd_data   (rbuf_data),
        .count     (rcount),
        .full      (rfull_unused)
    );

    // Capture the two header dwords as they are appended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr0_q <= '0;
            hdr1_q <= '0;
        end else if (wr_wmb && !wfull && !clear_mbx) begin
            if (wcount == CW'(0)) hdr0_q <= reg_wdata;
            if (wcount == CW'(1)) hdr1_q <= reg_wdata;
        end
    end

    // Read index into the response.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ridx_q <= '0;
        else if (clear_mbx)                    ridx_q <= '0;
        else if (wr_rmb && ridx_q < rcount)    ridx_q <= ridx_q + 1'b1;
    end

    // Busy, Ready, Error and dispatch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            ready_q   <= 1'b0;
            err_q     <= 1'b0;
            hdl_valid <= 1'b0;
            hdl_sel   <= '0;
        end else begin
            hdl_valid <= go_ok;
            if (go_ok) hdl_sel <= hit_sel;
            if (abort)         busy_q <= 1'b0;
            else if (go_ok)    busy_q <= 1'b1;
            else if (done_evt) busy_q <= 1'b0;
            ready_q <= (ready_q && !abort && !drain_end) || ok_evt;
            err_q   <= !abort && (err_q || ovf_err || und_err);
        end
    end

    // Interrupt enable, Interrupt Status (write-1-to-clear) and the request pulse.
    assign set_evt  = ok_evt || ovf_err || und_err;
    assign int_clr  = wr_stat && reg_be[0] && reg_wdata[ST_INT];
    assign int_base = intr_q && !int_clr;
    assign fire     = set_evt && INTR_SUPP && ien_q && !int_base;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            intr_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (wr_ctrl && !abort && reg_be[0]) ien_q <= reg_wdata[CTRL_IEN];
            intr_q <= int_base || fire;
            irq    <= fire;
        end
    end

    // Read mux, masked per byte lane.
    always_comb begin
        raw = '0;
        if (reg_rd && aligned) begin
            case (slot)
                SLOT_CAP:  raw = {20'b0, INTR_VEC, INTR_SUPP};
                SLOT_CTRL: raw[CTRL_IEN] = ien_q;
                SLOT_STAT: begin
                    raw[ST_BUSY] = busy_q;
                    raw[ST_INT]  = intr_q;
                    raw[ST_ERR]  = err_q;
                    raw[ST_RDY]  = ready_q;
                end
                SLOT_RMB:  raw = (full_dw && ready_q && !err_q) ? rbuf_data : '0;
                default:   raw = '0;
            endcase
        end
        reg_rdata = raw & {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
    end

    // R4
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_valid |-> busy_q);
    // R11
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> intr_q);
    // R10
    ridx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ridx_q <= rcount);
    // R6
    abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!ready_q && !err_q && !busy_q && wcount == '0));
    // R3
    go_err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_try && err_q) |=> !hdl_valid);
endmodule

// File: tb/test_objmb_regs.sv
`timescale 1ns/1ps
module test_objmb_regs;
    localparam int DEPTH = 8;
    localparam logic [4:0] A_CAP = 5'h00, A_CTRL = 5'h04, A_STAT = 5'h08,
                           A_WMB = 5'h0C, A_RMB = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hdl_valid;
    logic [0:0]  hdl_sel;
    logic [3:0]  hreq_idx = '0;
    logic [31:0] hreq_data;
    logic        hrsp_we = 1'b0;
    logic [31:0] hrsp_data = '0;
    logic        hdl_done = 1'b0, hdl_ok = 1'b0;
    logic        irq;

    int nchk = 0, nerr = 0, hv_cnt = 0, irq_cnt = 0;
    logic [31:0] ids [2] = '{32'h0005_1234, 32'h0011_ABCD};

    always #4 clk = ~clk;

    objmb_regs #(.DEPTH(DEPTH), .NUM_PROT(2), .PROT_IDS({24'h11ABCD, 24'h051234}),
                 .INTR_SUPP(1'b1), .INTR_VEC(11'd5)) i_objmb_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hdl_valid(hdl_valid), .hdl_sel(hdl_sel), .hreq_idx(hreq_idx), .hreq_data(hreq_data),
        .hrsp_we(hrsp_we), .hrsp_data(hrsp_data), .hdl_done(hdl_done), .hdl_ok(hdl_ok),
        .irq(irq));

    always @(posedge clk) begin
        if (hdl_valid) hv_cnt <= hv_cnt + 1;
        if (irq)       irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] rword(input int t, input int k);
        return 32'hA500_0000 ^ 32'(t << 8) ^ 32'(k);
    endfunction

    task automatic load(input logic [31:0] id, input logic [31:0] lenf, input int npay, input int seed);
        wr(A_WMB, 4'hF, id);
        wr(A_WMB, 4'hF, lenf);
        for (int i = 0; i < npay; i++) wr(A_WMB, 4'hF, 32'(seed + i));
    endtask

    task automatic go();
        wr(A_CTRL, 4'h8, 32'h8000_0000);
    endtask

    task automatic respond(input int n, input bit ok, input int t);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hrsp_we = 1'b1; hrsp_data = rword(t, k);
        end
        @(negedge clk);
        hrsp_we = 1'b0; hdl_done = 1'b1; hdl_ok = ok;
        @(negedge clk);
        hdl_done = 1'b0; hdl_ok = 1'b0;
    endtask

    task automatic drain(input int n, input int t, input string tag);
        logic [31:0] d;
        for (int k = 0; k < n; k++) begin
            rd(A_RMB, 4'hF, d);
            chk(tag, d, rword(t, k));
            wr(A_RMB, 4'hF, 32'h0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int hv0, irq0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // Reset state
        rd(A_STAT, 4'hF, d); chk("R8 reset status", d, 32'h0);
        rd(A_CTRL, 4'hF, d); chk("R7 reset control", d, 32'h0);
        rd(A_CAP, 4'hF, d);  chk("R7 capability", d, 32'h0000_000B);
        rd(A_RMB, 4'hF, d);  chk("R9 empty read mailbox", d, 32'h0);

        // Sweep: both protocols, every request length up to DEPTH
        for (int p = 0; p < 2; p++) begin
            for (int len = 2; len <= DEPTH; len++) begin
                load(ids[p], 32'(len), len - 2, len * 16);
                go();
                chk("R4 dispatch pulse", 32'(hdl_valid), 32'h1);
                chk("R4 protocol index", 32'(hdl_sel), 32'(p));
                hreq_idx = 4'd1; #1;
                chk("R1 stored length dword", hreq_data, 32'(len));
                if (len > 2) begin
                    hreq_idx = 4'(len - 1); #1;
                    chk("R1 last payload dword", hreq_data, 32'(len * 16 + len - 3));
                end
                rd(A_STAT, 4'hF, d); chk("R8 busy", d, 32'h1);
                respond(len, 1'b1, p * 16 + len);
                rd(A_STAT, 4'hF, d); chk("R5 ready after success", d, 32'h8000_0000);
                drain(len, p * 16 + len, "R9 response dword");
                rd(A_STAT, 4'hF, d); chk("R10 drained clears ready", d, 32'h0);
            end
        end

        // R2 length mismatch, then a clean request proves the write mailbox emptied
        load(ids[0], 32'd5, 2, 100);
        go();
        chk("R2 short request dropped", 32'(hdl_valid), 32'h0);
        load(ids[0], 32'd3, 1, 200);
        go();
        chk("R2 dispatch after drop", 32'(hdl_valid), 32'h1);
        hreq_idx = 4'd2; #1;
        chk("R2 mailbox restarted", hreq_data, 32'd200);
        respond(1, 1'b1, 50);
        drain(1, 50, "R9 after drop");

        // R2 zero length means maximum, upper bits ignored
        load(ids[0], 32'h0, 0, 0);
        go();
        chk("R2 zero length dropped", 32'(hdl_valid), 32'h0);
        load(ids[1], 32'hFFFC_0003, 1, 7);
        go();
        chk("R2 upper length bits ignored", 32'(hdl_valid), 32'h1);
        respond(1, 1'b1, 51);
        drain(1, 51, "R9 upper bits");

        // R2 unknown identifier
        load(32'h0005_1235, 32'd2, 0, 0);
        go();
        chk("R2 unknown protocol dropped", 32'(hdl_valid), 32'h0);

        // R1 partial write ignored
        wr(A_WMB, 4'hF, ids[0]);
        wr(A_WMB, 4'h3, 32'hDEAD_BEEF);
        wr(A_WMB, 4'hF, 32'd3);
        wr(A_WMB, 4'hF, 32'd77);
        go();
        chk("R1 partial write ignored", 32'(hdl_valid), 32'h1);
        respond(1, 1'b1, 52);
        drain(1, 52, "R9 after partial");

        // R3 Go ignored while busy
        hv0 = hv_cnt;
        load(ids[1], 32'd2, 0, 0);
        go();
        go();
        respond(2, 1'b1, 53);
        idle(2);
        chk("R3 go while busy ignored", 32'(hv_cnt - hv0), 32'h1);
        // R10 partial write to read mailbox does not advance, R9 partial read returns 0
        wr(A_RMB, 4'h1, 32'h0);
        rd(A_RMB, 4'hF, d); chk("R10 partial step ignored", d, rword(53, 0));
        rd(A_RMB, 4'h3, d); chk("R9 partial read zero", d, 32'h0);
        drain(2, 53, "R9 after partial step");

        // R5 handler failure
        load(ids[0], 32'd2, 0, 0);
        go();
        respond(2, 1'b0, 54);
        rd(A_STAT, 4'hF, d); chk("R5 failure leaves ready clear", d, 32'h0);
        rd(A_RMB, 4'hF, d);  chk("R5 no response after failure", d, 32'h0);
        load(ids[0], 32'd2, 0, 0);
        go();
        hreq_idx = 4'd1; #1;
        chk("R5 mailbox emptied by failure", hreq_data, 32'd2);
        respond(1, 1'b1, 55);
        drain(1, 55, "R9 after failure");

        // R1 overflow sets Error, R3 Go ignored while Error
        for (int i = 0; i <= DEPTH; i++) wr(A_WMB, 4'hF, (i == 0) ? ids[0] : 32'(DEPTH));
        rd(A_STAT, 4'hF, d); chk("R1 overflow error", d, 32'h4);
        go();
        chk("R3 go blocked by error", 32'(hdl_valid), 32'h0);
        // R6 abort with other bits set
        wr(A_CTRL, 4'hF, 32'h8000_0003);
        chk("R6 abort suppresses go", 32'(hdl_valid), 32'h0);
        rd(A_STAT, 4'hF, d); chk("R6 abort clears status", d, 32'h0);
        rd(A_CTRL, 4'hF, d); chk("R6 abort ignores enable bit", d, 32'h0);

        // R6 abort while busy: late done has no effect
        load(ids[0], 32'd2, 0, 0);
        go();
        wr(A_CTRL, 4'h1, 32'h1);
        respond(1, 1'b1, 56);
        rd(A_STAT, 4'hF, d); chk("R6 late done after abort", d, 32'h0);

        // R11 interrupts
        wr(A_CTRL, 4'h1, 32'h2);
        rd(A_CTRL, 4'hF, d); chk("R7 enable reads back", d, 32'h2);
        irq0 = irq_cnt;
        load(ids[0], 32'd2, 0, 0); go(); respond(1, 1'b1, 57);
        idle(2);
        chk("R11 pulse on ready", 32'(irq_cnt - irq0), 32'h1);
        rd(A_STAT, 4'hF, d); chk("R11 status set", d, 32'h8000_0002);
        drain(1, 57, "R9 irq run");
        load(ids[0], 32'd2, 0, 0); go(); respond(1, 1'b1, 58);
        idle(2);
        chk("R11 no pulse while pending", 32'(irq_cnt - irq0), 32'h1);
        drain(1, 58, "R9 irq run 2");
        // same-cycle clear and completion
        load(ids[0], 32'd2, 0, 0); go();
        @(negedge clk);
        hrsp_we = 1'b1; hrsp_data = rword(59, 0);
        @(negedge clk);
        hrsp_we = 1'b0; hdl_done = 1'b1; hdl_ok = 1'b1;
        reg_addr = A_STAT; reg_be = 4'h1; reg_wdata = 32'h2; reg_wr = 1'b1;
        @(negedge clk);
        hdl_done = 1'b0; hdl_ok = 1'b0; reg_wr = 1'b0;
        idle(2);
        chk("R11 clear and set same cycle pulse", 32'(irq_cnt - irq0), 32'h2);
        rd(A_STAT, 4'hF, d); chk("R11 clear and set same cycle status", d, 32'h8000_0002);
        drain(1, 59, "R9 collision run");
        wr(A_STAT, 4'h1, 32'h2);
        rd(A_STAT, 4'hF, d); chk("R11 write one clears", d, 32'h0);
        // R10 underrun sets Error and interrupts
        wr(A_RMB, 4'hF, 32'h0);
        idle(2);
        chk("R11 pulse on error", 32'(irq_cnt - irq0), 32'h3);
        rd(A_STAT, 4'hF, d); chk("R10 underrun error", d, 32'h6);
        rd(A_RMB, 4'hF, d);  chk("R9 read zero during error", d, 32'h0);
        wr(A_CTRL, 4'h1, 32'h1);
        rd(A_STAT, 4'hF, d); chk("R6 abort keeps interrupt status", d, 32'h2);

        finish_run();
    end
endmodule